// File: doc/BRIEF.md
# CAN Fault-Confinement Error Counters

This block keeps the transmit and receive error counts of a CAN node and derives the node's fault-confinement state from them: error active, error passive or bus off. The counters run in the protocol clock domain and are updated by single-cycle event pulses from the protocol engine. From the state it tells the frame logic which kind of error flag to send, and whether to hold back the start of a transmission.

A CPU in a separate bus clock domain sees both counts through a 16-bit read word. In test or freeze mode the CPU may also load new counts. Such a write is indirect. The value is captured in an auxiliary register in the bus domain. A toggle request then crosses into the protocol domain, where the counters are loaded, and a toggle acknowledge returns. While the transfer is pending a busy flag is raised. Software can also poll the read word until it shows the written value.

Top module: `can_err_counters`

## Requirements
- R1: After reset both counts are 0, the state is error active (code 00), wr_busy_o is 0 and rd_data_o is 0.
- R2: A tx_err_i pulse adds 8 to the transmit count. A tx_ok_i pulse subtracts 1, and the count stays at 0 if it is already 0. If both pulses arrive in the same cycle, the error wins.
- R3: An rx_err_i pulse adds 1 to the receive count, which saturates at 255. An rx_ok_i pulse subtracts 1, and the count stays at 0 if it is already 0. If both arrive together, the error wins.
- R4: conf_state_o is 10 (bus off) when the 9-bit transmit count exceeds 255. Otherwise it is 01 (error passive) when either count exceeds 127, and 00 (error active) in all other cases.
- R5: passive_flag_o is 1 whenever the state is not error active. tx_delay_o is 1 only in the error-passive state.
- R6: While bus off, tx_err_i and tx_ok_i leave the transmit count unchanged, rx events are still counted, and tx_cnt_o shows the low 8 bits of the 9-bit count.
- R7: A write on wr_en_i is accepted only when test_mode_i or freeze_i is 1. Otherwise it has no effect on the counts or on wr_busy_o.
- R8: An accepted write loads wr_data_i[15:8] into the transmit count and wr_data_i[7:0] into the receive count, and clears the bus-off bit. wr_busy_o is 1 from the bus clock edge after acceptance until the protocol domain has acknowledged the load.
- R9: A write presented while wr_busy_o is 1 is ignored.
- R10: rd_data_o carries {transmit count low byte, receive count} resynchronised into the bus domain. After a write completes, it reaches the written value.
- R11: When a CPU load lands in the same protocol cycle as event pulses, the loaded values take effect and the events of that cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus (CPU) clock |
| can_clk_i | input | 1 | Protocol clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| test_mode_i | input | 1 | Test mode, enables writes |
| freeze_i | input | 1 | Freeze mode, enables writes |
| wr_en_i | input | 1 | Write strobe, bus domain |
| wr_data_i | input | 16 | Write value {tx count, rx count} |
| rd_data_o | output | 16 | Read value {tx count, rx count}, bus domain |
| wr_busy_o | output | 1 | Write transfer pending |
| tx_err_i | input | 1 | Transmit error event, protocol domain |
| tx_ok_i | input | 1 | Successful transmission event |
| rx_err_i | input | 1 | Receive error event |
| rx_ok_i | input | 1 | Successful reception event |
| tx_cnt_o | output | 8 | Transmit count, low 8 bits |
| rx_cnt_o | output | 8 | Receive count |
| conf_state_o | output | 2 | 00 active, 01 passive, 10 bus off |
| passive_flag_o | output | 1 | 1: send passive error flag, 0: active flag |
| tx_delay_o | output | 1 | Request delayed transmission start |

## Verification
The hardest case to reach is a CPU load arriving in the very protocol cycle that carries an event, because that cycle is set by the synchroniser, not by the bench. The stimulus avoids having to predict it. It first drives the receive count to saturation, then holds rx_err_i high in every protocol cycle while the write crosses over. Every possible landing cycle then collides with an event. A lost load would leave the count at 255, while a load that wins restarts the count from the written 0.

// File: rtl/can_ec_pkg.sv
package can_ec_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUS_OFF = 2'b10
  } conf_state_e;
endpackage

// File: rtl/can_ec_sync.sv
module can_ec_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES+1];
  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g+1] <= '0;
      else         chain[g+1] <= chain[g];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/can_ec_wr_bridge.sv
module can_ec_wr_bridge #(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          test_mode_i,
  input  logic          freeze_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ack_tgl_i,
  output logic          req_tgl_o,
  output logic [DW-1:0] aux_o,
  output logic          busy_o
);
  logic ack_s;
  logic accept;

  can_ec_sync #(.W(1), .STAGES(SYNC_STAGES)) i_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tgl_i),
    .q_o   (ack_s)
  );

  assign busy_o = req_tgl_o ^ ack_s;
  assign accept = wr_en_i && (test_mode_i || freeze_i) && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tgl_o <= 1'b0;
      aux_o     <= '0;
    end else if (accept) begin
      req_tgl_o <= ~req_tgl_o;
      aux_o     <= wr_data_i;
    end
  end

  // R9
  aux_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(aux_o));

  // R7
  no_mode_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !test_mode_i && !freeze_i) |=> $stable(req_tgl_o));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (test_mode_i || freeze_i) && !busy_o) |=> busy_o);
endmodule

// File: rtl/can_ec_core.sv
module can_ec_core
  import can_ec_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TX_STEP     = 8,
  parameter int PASSIVE_LIM = 127,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_tgl_i,
  input  logic [2*CNT_W-1:0] aux_i,
  input  logic               tx_err_i,
  input  logic               tx_ok_i,
  input  logic               rx_err_i,
  input  logic               rx_ok_i,
  output logic               ack_tgl_o,
  output logic [CNT_W:0]     tec_o,
  output logic [CNT_W-1:0]   rec_o,
  output conf_state_e        state_o
);
  localparam int TW = CNT_W + 1;
  localparam logic [TW-1:0]    TEC_STEP = TW'(TX_STEP);
  localparam logic [TW-1:0]    TEC_LIM  = TW'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] REC_LIM  = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] REC_MAX  = '1;

  logic           req_s, seen_q, load;
  logic           bus_off;
  logic [TW-1:0]  tec_q, tec_d;
  logic [CNT_W-1:0] rec_q, rec_d;

  can_ec_sync #(.W(1), .STAGES(SYNC_STAGES)) i_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_i),
    .q_o   (req_s)
  );

  assign load    = req_s ^ seen_q;
  assign bus_off = tec_q[CNT_W];

  // CPU load has priority over same-cycle events
  always_comb begin
    tec_d = tec_q;
    if (load) begin
      tec_d = {1'b0, aux_i[2*CNT_W-1:CNT_W]};
    end else if (!bus_off) begin
      if (tx_err_i)                   tec_d = tec_q + TEC_STEP;
      else if (tx_ok_i && tec_q != '0) tec_d = tec_q - 1'b1;
    end
  end

  always_comb begin
    rec_d = rec_q;
    if (load) begin
      rec_d = aux_i[CNT_W-1:0];
    end else if (rx_err_i) begin
      if (rec_q != REC_MAX) rec_d = rec_q + 1'b1;
    end else if (rx_ok_i && rec_q != '0) begin
      rec_d = rec_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tec_q  <= '0;
      rec_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      tec_q  <= tec_d;
      rec_q  <= rec_d;
      seen_q <= req_s;
    end
  end

  always_comb begin
    if (bus_off)                              state_o = ST_BUS_OFF;
    else if (tec_q > TEC_LIM || rec_q > REC_LIM) state_o = ST_PASSIVE;
    else                                      state_o = ST_ACTIVE;
  end

  assign ack_tgl_o = seen_q;
  assign tec_o     = tec_q;
  assign rec_o     = rec_q;

  // R3
  rec_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_q == REC_MAX && rx_err_i && !load) |=> rec_q == REC_MAX);

  // R6
  bus_off_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off && !load) |=> $stable(tec_q));

  // R11
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (rec_q == $past(aux_i[CNT_W-1:0])) && !tec_q[CNT_W]);

  // R2
  tec_no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tec_q == '0 && !tx_err_i && !load) |=> tec_q == '0);
endmodule

// File: rtl/can_err_counters.sv
module can_err_counters
  import can_ec_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TX_STEP     = 8,
  parameter int PASSIVE_LIM = 127,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               can_clk_i,
  input  logic               rst_ni,
  input  logic               test_mode_i,
  input  logic               freeze_i,
  input  logic               wr_en_i,
  input  logic [2*CNT_W-1:0] wr_data_i,
  output logic [2*CNT_W-1:0] rd_data_o,
  output logic               wr_busy_o,
  input  logic               tx_err_i,
  input  logic               tx_ok_i,
  input  logic               rx_err_i,
  input  logic               rx_ok_i,
  output logic [CNT_W-1:0]   tx_cnt_o,
  output logic [CNT_W-1:0]   rx_cnt_o,
  output logic [1:0]         conf_state_o,
  output logic               passive_flag_o,
  output logic               tx_delay_o
);
  localparam int DW = 2 * CNT_W;

  logic              req_tgl, ack_tgl;
  logic [DW-1:0]     aux;
  logic [CNT_W:0]    tec;
  logic [CNT_W-1:0]  rec;
  conf_state_e       state;

  can_ec_wr_bridge #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) i_bridge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .test_mode_i(test_mode_i),
    .freeze_i   (freeze_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .ack_tgl_i  (ack_tgl),
    .req_tgl_o  (req_tgl),
    .aux_o      (aux),
    .busy_o     (wr_busy_o)
  );

  can_ec_core #(
    .CNT_W      (CNT_W),
    .TX_STEP    (TX_STEP),
    .PASSIVE_LIM(PASSIVE_LIM),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_core (
    .clk_i    (can_clk_i),
    .rst_ni   (rst_ni),
    .req_tgl_i(req_tgl),
    .aux_i    (aux),
    .tx_err_i (tx_err_i),
    .tx_ok_i  (tx_ok_i),
    .rx_err_i (rx_err_i),
    .rx_ok_i  (rx_ok_i),
    .ack_tgl_o(ack_tgl),
    .tec_o    (tec),
    .rec_o    (rec),
    .state_o  (state)
  );

  // read path: per-bit resync for polling
  can_ec_sync #(.W(DW), .STAGES(SYNC_STAGES)) i_rd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tec[CNT_W-1:0], rec}),
    .q_o   (rd_data_o)
  );

  assign tx_cnt_o       = tec[CNT_W-1:0];
  assign rx_cnt_o       = rec;
  assign conf_state_o   = state;
  assign passive_flag_o = (state != ST_ACTIVE);
  assign tx_delay_o     = (state == ST_PASSIVE);

  // R5
  delay_only_passive_chk: assert property (@(posedge can_clk_i) disable iff (!rst_ni)
    tx_delay_o |-> (passive_flag_o && !tec[CNT_W]));

  // R4
  state_legal_chk: assert property (@(posedge can_clk_i) disable iff (!rst_ni)
    conf_state_o != 2'b11);
endmodule

// File: tb/test_can_err_counters.sv
module test_can_err_counters;
  logic clk = 0, can_clk = 0, rst_n = 0;
  logic test_mode = 0, freeze = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic wr_busy;
  logic tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0;
  logic [7:0] tx_cnt, rx_cnt;
  logic [1:0] conf_state;
  logic passive_flag, tx_delay;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;     // 50 MHz bus clock
  always #8  can_clk = ~can_clk;

  can_err_counters i_can_err_counters (
    .clk_i(clk), .can_clk_i(can_clk), .rst_ni(rst_n),
    .test_mode_i(test_mode), .freeze_i(freeze),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data), .wr_busy_o(wr_busy),
    .tx_err_i(tx_err), .tx_ok_i(tx_ok), .rx_err_i(rx_err), .rx_ok_i(rx_ok),
    .tx_cnt_o(tx_cnt), .rx_cnt_o(rx_cnt), .conf_state_o(conf_state),
    .passive_flag_o(passive_flag), .tx_delay_o(tx_delay)
  );

  typedef struct {
    int    tec;
    int    rec;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int m_tec = 0, m_rec = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int st_of(int t, int r);
    if (t > 255) return 2;
    if (t > 127 || r > 127) return 1;
    return 0;
  endfunction

  // driver: one protocol cycle of events, expected result queued
  task automatic ev(bit te, bit to, bit re, bit ro, string tag);
    @(negedge can_clk);
    tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro;
    @(posedge can_clk);
    #1;
    tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0;
    if (m_tec <= 255) begin
      if (te) m_tec += 8;
      else if (to && m_tec > 0) m_tec -= 1;
    end
    if (re) begin
      if (m_rec < 255) m_rec += 1;
    end else if (ro && m_rec > 0) m_rec -= 1;
    exp_q.push_back('{m_tec, m_rec, tag});
  endtask

  // monitor
  always @(negedge can_clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      int s;
      e = exp_q.pop_front();
      s = st_of(e.tec, e.rec);
      chk(tx_cnt == 8'(e.tec), {e.tag, " tx_cnt"}, tx_cnt, e.tec % 256);
      chk(rx_cnt == 8'(e.rec), {e.tag, " rx_cnt"}, rx_cnt, e.rec);
      chk(int'(conf_state) == s, "R4 state", conf_state, s);
      chk(passive_flag == (s != 0), "R5 passive_flag", passive_flag, s != 0);
      chk(tx_delay == (s == 1), "R5 tx_delay", tx_delay, s == 1);
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 100 && wr_busy; i++) @(negedge clk);
  endtask

  // accepted write: check busy, completion, counts and read-back poll
  task automatic cpu_write(logic [15:0] d, string tag);
    bit seen;
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    chk(wr_busy == 1, "R8 busy after accept", wr_busy, 1);
    wait_idle();
    chk(wr_busy == 0, "R8 busy clears", wr_busy, 0);
    @(negedge can_clk);
    chk(tx_cnt == d[15:8], {tag, " tx load"}, tx_cnt, d[15:8]);
    chk(rx_cnt == d[7:0], {tag, " rx load"}, rx_cnt, d[7:0]);
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (rd_data == d) seen = 1;
    end
    chk(seen, "R10 poll read-back", rd_data, d);
    m_tec = d[15:8]; m_rec = d[7:0];
  endtask

  initial begin
    #(100000 * 20);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #95 rst_n = 1;
    @(negedge can_clk);
    chk(tx_cnt == 0 && rx_cnt == 0, "R1 counts", {tx_cnt, rx_cnt}, 0);
    chk(conf_state == 2'b00, "R1 state", conf_state, 0);
    chk(wr_busy == 0, "R1 busy", wr_busy, 0);
    @(negedge clk);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);

    // R2 transmit counting
    ev(1, 0, 0, 0, "R2 err");
    ev(0, 1, 0, 0, "R2 ok");
    ev(1, 1, 0, 0, "R2 both");
    for (int i = 0; i < 15; i++) ev(0, 1, 0, 0, "R2 down");
    ev(0, 1, 0, 0, "R2 floor");

    // R3 receive counting
    for (int i = 0; i < 3; i++) ev(0, 0, 1, 0, "R3 err");
    ev(0, 0, 1, 1, "R3 both");
    for (int i = 0; i < 5; i++) ev(0, 0, 0, 1, "R3 down/floor");
    @(negedge can_clk);

    // R7 writes ignored outside test/freeze
    @(negedge clk);
    wr_en = 1; wr_data = 16'h3344;
    @(negedge clk);
    wr_en = 0;
    chk(wr_busy == 0, "R7 busy", wr_busy, 0);
    repeat (20) @(negedge clk);
    @(negedge can_clk);
    chk(tx_cnt == 8'(m_tec), "R7 tx unchanged", tx_cnt, m_tec);
    chk(rx_cnt == 8'(m_rec), "R7 rx unchanged", rx_cnt, m_rec);

    // R8/R3 saturation and passive via rx
    freeze = 1;
    cpu_write(16'h78FA, "R8");
    for (int i = 0; i < 6; i++) ev(0, 0, 1, 0, "R3 sat");

    // R4 passive boundary on tx
    cpu_write(16'h7800, "R8");
    ev(1, 0, 0, 0, "R4 to passive");
    ev(0, 1, 0, 0, "R4 back to active");

    // R6 bus off
    cpu_write(16'hF800, "R8");
    ev(1, 0, 0, 0, "R6 enter bus off");
    ev(0, 1, 0, 0, "R6 tx_ok ignored");
    ev(1, 0, 0, 0, "R6 tx_err ignored");
    ev(0, 0, 1, 0, "R6 rx counted");
    @(negedge can_clk);

    // R8 write via test mode clears bus off
    freeze = 0; test_mode = 1;
    cpu_write(16'h0500, "R8 clears bus off");
    @(negedge can_clk);
    chk(conf_state == 2'b00, "R8 state after load", conf_state, 0);

    // R9 write while busy ignored
    @(negedge clk);
    wr_en = 1; wr_data = 16'h2211;
    @(negedge clk);
    wr_data = 16'h6655;
    @(negedge clk);
    wr_en = 0;
    wait_idle();
    repeat (10) @(negedge clk);
    chk(wr_busy == 0, "R9 no second transfer", wr_busy, 0);
    @(negedge can_clk);
    chk({tx_cnt, rx_cnt} == 16'h2211, "R9 first value kept", {tx_cnt, rx_cnt}, 16'h2211);

    // R11 load collides with held rx errors
    cpu_write(16'h00FA, "R8");
    @(negedge can_clk);
    rx_err = 1;
    repeat (10) @(negedge can_clk);
    chk(rx_cnt == 255, "R3 saturated", rx_cnt, 255);
    @(negedge clk);
    wr_en = 1; wr_data = 16'h1000;
    @(negedge clk);
    wr_en = 0;
    wait_idle();
    @(negedge can_clk);
    rx_err = 0;
    @(negedge can_clk);
    chk(rx_cnt < 40, "R11 load not lost", rx_cnt, 0);
    chk(tx_cnt == 8'h10, "R11 tx loaded", tx_cnt, 16);

    repeat (4) @(negedge can_clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule